// File: doc/BRIEF.md
# Ethernet VLAN Ingress Classifier

This block watches the head of every received frame as it streams past, eight bytes per beat, and decides whether the frame belongs to a known slice. It checks the frame length reported by the link layer, the tag protocol identifier, and whether the destination MAC is this station's own address. It then looks the 12-bit VLAN ID up in a table that has one entry for every VLAN. Each entry holds a 4-bit code option and a 32-bit slice data pointer. A code option of zero marks the slice as unknown.

Exactly one result leaves the block for each frame. A result is either a pass, which carries the code option and the pointer, or a drop, which carries one cause code. When a frame has several faults, only the highest-priority fault is reported and counted. Six free-running counters record frames received, frames passed, and drops for each of the four causes.

Software writes the table through a one-cycle write port. Bytes after the VLAN tag are consumed without inspection. The CRC is not checked here.

Top module: `vlan_ingress_classifier`

## Requirements
- R1: A frame is dropped with cause 1 (length) when `in_len`, taken on the start beat, is below 64 or above 1522 (1518 plus the 4-byte tag). A frame that ends on its first beat is also dropped with cause 1, whatever its reported length.
- R2: A frame is dropped with cause 2 (tag) when bytes 12..13, taken as a big-endian value, differ from 0x8100.
- R3: A frame is dropped with cause 3 (destination) when bytes 0..5 differ from `{mac_hi, mac_lo}`. Byte 0 is compared with `mac_hi[31:24]` and byte 5 with `mac_lo[7:0]`.
- R4: A frame is dropped with cause 4 (VLAN) when the table entry for its VLAN ID holds code option 0.
- R5: Causes are tested in the order length, tag, destination, VLAN. The result reports the first one that fails, and only that cause's counter advances.
- R6: A passing frame yields `res_pass`=1, cause 0, the entry's code option and pointer, and the VLAN ID. A dropped frame yields `res_pass`=0, a code of 0 and a pointer of 0. On a drop, `res_vid` holds the VLAN ID, except for a first-beat-only frame, where it is 0.
- R7: `cnt_rx` advances by one for each result. `cnt_pass` advances for each pass. Each drop counter advances for its own cause. `cnt_rx` always equals the sum of the other five counters.
- R8: After reset every counter is 0 and every table entry has code 0, except entry 0xAAA, which has code 1 and pointer 0.
- R9: A table write takes effect at the clock edge on which `tbl_we` is high. A lookup made on that same edge still sees the old entry. Writing code 0 makes a VLAN unrecognized.
- R10: `in_ready` drops only while a result is waiting and `res_ready` is low, and then only on header beats. Beats after the tag are always accepted. A held result keeps every field stable until it is taken. A beat without `in_sof` that arrives outside a frame produces no result and no count.
- R11: Byte 0 of a beat sits in `in_data[63:56]`. The VLAN ID is `in_data[11:0]` of the second beat. The result becomes valid on the edge that accepts the second beat, or the first beat if that beat also ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with `in_valid` |
| in_data | input | 64 | Eight frame bytes, byte 0 in the top bits |
| in_sof | input | 1 | First beat of a frame |
| in_eof | input | 1 | Last beat of a frame |
| in_len | input | 16 | Frame length in bytes from the link layer, read on the first beat |
| mac_hi | input | 32 | Upper 4 bytes of the local MAC address |
| mac_lo | input | 16 | Lower 2 bytes of the local MAC address |
| tbl_we | input | 1 | Table write strobe |
| tbl_vid | input | 12 | VLAN ID to write |
| tbl_code | input | 4 | Code option to store |
| tbl_ptr | input | 32 | Slice data pointer to store |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken when high with `res_valid` |
| res_pass | output | 1 | Frame accepted |
| res_cause | output | 3 | 0 pass, 1 length, 2 tag, 3 destination, 4 VLAN |
| res_vid | output | 12 | VLAN ID of the frame |
| res_code | output | 4 | Code option, 0 on drop |
| res_ptr | output | 32 | Slice data pointer, 0 on drop |
| cnt_rx | output | 32 | Frames decided |
| cnt_pass | output | 32 | Frames passed |
| cnt_drop_len | output | 32 | Length drops |
| cnt_drop_tpid | output | 32 | Tag drops |
| cnt_drop_dst | output | 32 | Destination drops |
| cnt_drop_vlan | output | 32 | VLAN drops |

## Verification
The length sweep covers every value just inside and just outside both bounds. An off-by-one comparator would misclassify 63, 64, 1522 or 1523. Every fault combination is driven, so a wrong priority would report, and count, the wrong cause. Single-bit flips over all 48 destination bits would expose a byte-order slip or a narrowed compare. All 4096 table entries are written and then looked up, which exposes index truncation. A write issued on the lookup edge would show a bypass that should not exist. A stalled result would reveal fields that drift, or beats that are accepted while the result waits.

// File: rtl/vlan_cls_pkg.sv
`timescale 1ns/1ps
package vlan_cls_pkg;
  localparam int CODE_W = 4;
  localparam int PTR_W  = 32;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_LEN  = 3'd1,
    CAUSE_TPID = 3'd2,
    CAUSE_DST  = 3'd3,
    CAUSE_VLAN = 3'd4
  } cause_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [PTR_W-1:0]  ptr;
  } slice_t;

  localparam int NUM_CNT   = 6;
  localparam int CNT_RX    = 0;
  localparam int CNT_PASS  = 1;
  localparam int CNT_LEN   = 2;
  localparam int CNT_TPID  = 3;
  localparam int CNT_DST   = 4;
  localparam int CNT_VLAN  = 5;
endpackage

// File: rtl/vlan_cls_table.sv
`timescale 1ns/1ps
module vlan_cls_table
  import vlan_cls_pkg::*;
#(
  parameter int                VID_W        = 12,
  parameter int                PRELOAD_VID  = 12'hAAA,
  parameter logic [CODE_W-1:0] PRELOAD_CODE = 4'd1,
  parameter logic [PTR_W-1:0]  PRELOAD_PTR  = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VID_W-1:0] wvid,
  input  slice_t           wentry,
  input  logic [VID_W-1:0] rvid,
  output slice_t           rentry
);
  localparam int DEPTH = 1 << VID_W;

  logic [CODE_W-1:0] code_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_q[i] <= (i == PRELOAD_VID) ? PRELOAD_CODE : '0;
        ptr_q[i]  <= (i == PRELOAD_VID) ? PRELOAD_PTR  : '0;
      end
    end else if (we) begin
      code_q[wvid] <= wentry.code;
      ptr_q[wvid]  <= wentry.ptr;
    end
  end

  // Read is combinational from the stored state, so a same-edge write is not seen.
  assign rentry.code = code_q[rvid];
  assign rentry.ptr  = ptr_q[rvid];
endmodule

// File: rtl/vlan_cls_parse.sv
`timescale 1ns/1ps
module vlan_cls_parse
  import vlan_cls_pkg::*;
#(
  parameter int          VID_W   = 12,
  parameter int          MIN_LEN = 64,
  parameter int          MAX_LEN = 1518,
  parameter int          TAG_LEN = 4,
  parameter logic [15:0] TPID    = 16'h8100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [63:0]        in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [15:0]        in_len,
  input  logic [31:0]        mac_hi,
  input  logic [15:0]        mac_lo,
  output logic [VID_W-1:0]   lk_vid,
  input  slice_t             lk_entry,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_pass,
  output logic [2:0]         res_cause,
  output logic [VID_W-1:0]   res_vid,
  output logic [CODE_W-1:0]  res_code,
  output logic [PTR_W-1:0]   res_ptr,
  output logic [NUM_CNT-1:0] inc
);
  localparam logic [15:0] LEN_LO = 16'(MIN_LEN);
  localparam logic [15:0] LEN_HI = 16'(MAX_LEN + TAG_LEN);

  typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_TAIL} st_e;

  st_e          st_q;
  logic [15:0]  len_q;
  logic         dst_ok_q;
  logic         rv_q;
  cause_e       cause_q;
  logic [VID_W-1:0]  vid_q;
  slice_t       ent_q;

  logic         accept, beat0, beat1, decide;
  logic [15:0]  len_src;
  logic         len_bad, tpid_bad, dst_bad, vlan_bad;
  cause_e       cause_d;

  assign in_ready = (st_q == ST_TAIL) || !rv_q || res_ready;
  assign accept   = in_valid && in_ready;
  assign beat0    = accept && (st_q == ST_IDLE) && in_sof;
  assign beat1    = accept && (st_q == ST_TAG);
  assign decide   = (beat0 && in_eof) || beat1;
  assign lk_vid   = in_data[VID_W-1:0];

  always_comb begin
    len_src  = beat0 ? in_len : len_q;
    len_bad  = beat0 || (len_src < LEN_LO) || (len_src > LEN_HI);
    tpid_bad = in_data[31:16] != TPID;
    dst_bad  = !dst_ok_q;
    vlan_bad = lk_entry.code == '0;
    if (len_bad)       cause_d = CAUSE_LEN;
    else if (tpid_bad) cause_d = CAUSE_TPID;
    else if (dst_bad)  cause_d = CAUSE_DST;
    else if (vlan_bad) cause_d = CAUSE_VLAN;
    else               cause_d = CAUSE_NONE;
  end

  always_comb begin
    inc           = '0;
    inc[CNT_RX]   = decide;
    inc[CNT_PASS] = decide && (cause_d == CAUSE_NONE);
    inc[CNT_LEN]  = decide && (cause_d == CAUSE_LEN);
    inc[CNT_TPID] = decide && (cause_d == CAUSE_TPID);
    inc[CNT_DST]  = decide && (cause_d == CAUSE_DST);
    inc[CNT_VLAN] = decide && (cause_d == CAUSE_VLAN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      len_q    <= '0;
      dst_ok_q <= 1'b0;
    end else begin
      if (beat0) begin
        len_q    <= in_len;
        dst_ok_q <= in_data[63:16] == {mac_hi, mac_lo};
      end
      unique case (st_q)
        ST_IDLE: if (beat0)            st_q <= in_eof ? ST_IDLE : ST_TAG;
        ST_TAG:  if (beat1)            st_q <= in_eof ? ST_IDLE : ST_TAIL;
        ST_TAIL: if (accept && in_eof) st_q <= ST_IDLE;
        default:                       st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
      vid_q   <= '0;
      ent_q   <= '0;
    end else if (decide) begin
      rv_q    <= 1'b1;
      cause_q <= cause_d;
      vid_q   <= beat1 ? in_data[VID_W-1:0] : '0;
      ent_q   <= (cause_d == CAUSE_NONE) ? lk_entry : '0;
    end else if (res_ready) begin
      rv_q    <= 1'b0;
    end
  end

  assign res_valid = rv_q;
  assign res_pass  = cause_q == CAUSE_NONE;
  assign res_cause = cause_q;
  assign res_vid   = vid_q;
  assign res_code  = ent_q.code;
  assign res_ptr   = ent_q.ptr;
endmodule

// File: rtl/vlan_cls_counters.sv
`timescale 1ns/1ps
module vlan_cls_counters #(
  parameter int N = 6,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + W'(1);
    end
  end
endmodule

// File: rtl/vlan_ingress_classifier.sv
`timescale 1ns/1ps
module vlan_ingress_classifier
  import vlan_cls_pkg::*;
#(
  parameter int          VID_W        = 12,
  parameter int          CNT_W        = 32,
  parameter int          MIN_LEN      = 64,
  parameter int          MAX_LEN      = 1518,
  parameter int          TAG_LEN      = 4,
  parameter logic [15:0] TPID         = 16'h8100,
  parameter int          PRELOAD_VID  = 12'hAAA,
  parameter logic [3:0]  PRELOAD_CODE = 4'd1,
  parameter logic [31:0] PRELOAD_PTR  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [15:0]       in_len,
  input  logic [31:0]       mac_hi,
  input  logic [15:0]       mac_lo,
  input  logic              tbl_we,
  input  logic [VID_W-1:0]  tbl_vid,
  input  logic [3:0]        tbl_code,
  input  logic [31:0]       tbl_ptr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_pass,
  output logic [2:0]        res_cause,
  output logic [VID_W-1:0]  res_vid,
  output logic [3:0]        res_code,
  output logic [31:0]       res_ptr,
  output logic [CNT_W-1:0]  cnt_rx,
  output logic [CNT_W-1:0]  cnt_pass,
  output logic [CNT_W-1:0]  cnt_drop_len,
  output logic [CNT_W-1:0]  cnt_drop_tpid,
  output logic [CNT_W-1:0]  cnt_drop_dst,
  output logic [CNT_W-1:0]  cnt_drop_vlan
);
  logic [VID_W-1:0]              lk_vid;
  slice_t                        lk_entry;
  slice_t                        wentry;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  assign wentry.code = tbl_code;
  assign wentry.ptr  = tbl_ptr;

  vlan_cls_table #(
    .VID_W(VID_W), .PRELOAD_VID(PRELOAD_VID),
    .PRELOAD_CODE(PRELOAD_CODE), .PRELOAD_PTR(PRELOAD_PTR)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wvid(tbl_vid), .wentry(wentry),
    .rvid(lk_vid), .rentry(lk_entry)
  );

  vlan_cls_parse #(
    .VID_W(VID_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .TAG_LEN(TAG_LEN), .TPID(TPID)
  ) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len),
    .mac_hi(mac_hi), .mac_lo(mac_lo), .lk_vid(lk_vid), .lk_entry(lk_entry),
    .res_valid(res_valid), .res_ready(res_ready), .res_pass(res_pass),
    .res_cause(res_cause), .res_vid(res_vid), .res_code(res_code),
    .res_ptr(res_ptr), .inc(inc)
  );

  vlan_cls_counters #(.N(NUM_CNT), .W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cnt(cnt)
  );

  assign cnt_rx        = cnt[CNT_RX];
  assign cnt_pass      = cnt[CNT_PASS];
  assign cnt_drop_len  = cnt[CNT_LEN];
  assign cnt_drop_tpid = cnt[CNT_TPID];
  assign cnt_drop_dst  = cnt[CNT_DST];
  assign cnt_drop_vlan = cnt[CNT_VLAN];
endmodule

// File: rtl/vlan_cls_checker.sv
`timescale 1ns/1ps
module vlan_cls_checker #(
  parameter int VID_W = 12,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_pass,
  input logic [2:0]       res_cause,
  input logic [VID_W-1:0] res_vid,
  input logic [3:0]       res_code,
  input logic [31:0]      res_ptr,
  input logic [CNT_W-1:0] cnt_rx,
  input logic [CNT_W-1:0] cnt_pass,
  input logic [CNT_W-1:0] cnt_drop_len,
  input logic [CNT_W-1:0] cnt_drop_tpid,
  input logic [CNT_W-1:0] cnt_drop_dst,
  input logic [CNT_W-1:0] cnt_drop_vlan
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_pass, res_cause, res_vid, res_code, res_ptr}));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> res_valid && !res_ready);

  assert_pass_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_pass |-> res_code != 4'd0 && res_cause == 3'd0);

  assert_drop_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_pass |-> res_code == 4'd0 && res_ptr == 32'd0 && res_cause != 3'd0);

  assert_cause_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_cause <= 3'd4);

  assert_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rx == cnt_pass + cnt_drop_len + cnt_drop_tpid + cnt_drop_dst + cnt_drop_vlan);

  assert_rx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rx != $past(cnt_rx) |-> res_valid && cnt_rx == $past(cnt_rx) + CNT_W'(1));
endmodule

bind vlan_ingress_classifier vlan_cls_checker #(.VID_W(VID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_pass(res_pass), .res_cause(res_cause),
  .res_vid(res_vid), .res_code(res_code), .res_ptr(res_ptr),
  .cnt_rx(cnt_rx), .cnt_pass(cnt_pass), .cnt_drop_len(cnt_drop_len),
  .cnt_drop_tpid(cnt_drop_tpid), .cnt_drop_dst(cnt_drop_dst),
  .cnt_drop_vlan(cnt_drop_vlan)
);

// File: tb/sim_vlan_ingress_classifier.sv
`timescale 1ns/1ps
module sim_vlan_ingress_classifier;
  localparam logic [31:0] MHI = 32'h02AB_CDEF;
  localparam logic [15:0] MLO = 16'h1234;
  localparam logic [47:0] MAC = {MHI, MLO};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic in_ready;
  logic [63:0] in_data = '0;
  logic [15:0] in_len = '0;
  logic tbl_we = 1'b0;
  logic [11:0] tbl_vid = '0;
  logic [3:0] tbl_code = '0;
  logic [31:0] tbl_ptr = '0;
  logic res_valid, res_pass;
  logic res_ready = 1'b1;
  logic [2:0] res_cause;
  logic [11:0] res_vid;
  logic [3:0] res_code;
  logic [31:0] res_ptr;
  logic [31:0] cnt_rx, cnt_pass, cnt_drop_len, cnt_drop_tpid, cnt_drop_dst, cnt_drop_vlan;

  always #10 clk = ~clk;

  vlan_ingress_classifier u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len),
    .mac_hi(MHI), .mac_lo(MLO), .tbl_we(tbl_we), .tbl_vid(tbl_vid),
    .tbl_code(tbl_code), .tbl_ptr(tbl_ptr), .res_valid(res_valid),
    .res_ready(res_ready), .res_pass(res_pass), .res_cause(res_cause),
    .res_vid(res_vid), .res_code(res_code), .res_ptr(res_ptr),
    .cnt_rx(cnt_rx), .cnt_pass(cnt_pass), .cnt_drop_len(cnt_drop_len),
    .cnt_drop_tpid(cnt_drop_tpid), .cnt_drop_dst(cnt_drop_dst),
    .cnt_drop_vlan(cnt_drop_vlan)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [3:0]  mcode [4096];
  logic [31:0] mptr  [4096];
  logic [31:0] mcnt  [6];
  logic [63:0] last_exp;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] result_now();
    return {11'd0, res_valid, res_pass, res_cause, res_code, res_ptr, res_vid};
  endfunction

  task automatic send(input string tag, input logic [15:0] len, input int nb,
                      input logic [47:0] dst, input logic [15:0] tpid,
                      input logic [11:0] vid, input bit wr,
                      input logic [3:0] wcode, input logic [31:0] wptr);
    int d;
    logic [2:0] c;
    logic pass;
    logic [63:0] e;
    d = (nb < 2) ? 0 : 1;
    if (nb < 2 || len < 16'd64 || len > 16'd1522) c = 3'd1;
    else if (tpid != 16'h8100)                    c = 3'd2;
    else if (dst != MAC)                          c = 3'd3;
    else if (mcode[vid] == 4'd0)                  c = 3'd4;
    else                                          c = 3'd0;
    pass = (c == 3'd0);
    e = {11'd0, 1'b1, pass, c, pass ? mcode[vid] : 4'd0, pass ? mptr[vid] : 32'd0,
         (nb < 2) ? 12'd0 : vid};
    last_exp = e;
    mcnt[0]++;
    if (pass) mcnt[1]++; else mcnt[1 + int'(c)]++;
    for (int i = 0; i <= nb; i++) begin
      @(negedge clk);
      tbl_we = 1'b0;
      if (i == d + 1) check(tag, result_now(), e);
      if (i < nb) begin
        in_valid = 1'b1;
        in_sof   = (i == 0);
        in_eof   = (i == nb - 1);
        in_len   = len;
        if (i == 0)      in_data = {dst, 16'h5A5A};
        else if (i == 1) in_data = {32'h0102_0304, tpid, 4'h0, vid};
        else             in_data = {8{8'(i)}};
        if (wr && i == d) begin
          tbl_we = 1'b1; tbl_vid = vid; tbl_code = wcode; tbl_ptr = wptr;
        end
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    if (wr) begin mcode[vid] = wcode; mptr[vid] = wptr; end
  endtask

  task automatic write_entry(input logic [11:0] vid, input logic [3:0] code, input logic [31:0] ptr);
    @(negedge clk);
    tbl_we = 1'b1; tbl_vid = vid; tbl_code = code; tbl_ptr = ptr;
    @(negedge clk);
    tbl_we = 1'b0;
    mcode[vid] = code; mptr[vid] = ptr;
  endtask

  task automatic check_counters(input string tag);
    check({tag, " R7 rx"},   {32'd0, cnt_rx},        {32'd0, mcnt[0]});
    check({tag, " R7 pass"}, {32'd0, cnt_pass},      {32'd0, mcnt[1]});
    check({tag, " R1 len"},  {32'd0, cnt_drop_len},  {32'd0, mcnt[2]});
    check({tag, " R2 tpid"}, {32'd0, cnt_drop_tpid}, {32'd0, mcnt[3]});
    check({tag, " R3 dst"},  {32'd0, cnt_drop_dst},  {32'd0, mcnt[4]});
    check({tag, " R4 vlan"}, {32'd0, cnt_drop_vlan}, {32'd0, mcnt[5]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 4096; v++) begin mcode[v] = 4'd0; mptr[v] = 32'd0; end
    mcode[12'hAAA] = 4'd1;
    for (int k = 0; k < 6; k++) mcnt[k] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    check_counters("R8 reset");
    check("R8 idle outputs", {62'd0, res_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    send("R8 preload AAA", 16'd100, 4, MAC, 16'h8100, 12'hAAA, 0, 0, 0);
    send("R8 cleared 000", 16'd100, 4, MAC, 16'h8100, 12'h000, 0, 0, 0);
    send("R8 cleared FFF", 16'd100, 4, MAC, 16'h8100, 12'hFFF, 0, 0, 0);
    send("R8 cleared AAB", 16'd100, 4, MAC, 16'h8100, 12'hAAB, 0, 0, 0);

    // R1: length bounds sweep, plus first-beat-only frames
    for (int l = 56; l <= 72; l++)
      send("R1 low bound", 16'(l), 3, MAC, 16'h8100, 12'hAAA, 0, 0, 0);
    for (int l = 1510; l <= 1530; l++)
      send("R1 high bound", 16'(l), 3, MAC, 16'h8100, 12'hAAA, 0, 0, 0);
    send("R1 runt", 16'd100, 1, MAC, 16'h8100, 12'hAAA, 0, 0, 0);
    send("R11 two-beat frame", 16'd64, 2, MAC, 16'h8100, 12'hAAA, 0, 0, 0);

    // R2: tag identifiers
    send("R2 tpid 88A8", 16'd80, 3, MAC, 16'h88A8, 12'hAAA, 0, 0, 0);
    send("R2 tpid 0800", 16'd80, 3, MAC, 16'h0800, 12'hAAA, 0, 0, 0);
    send("R2 tpid 8101", 16'd80, 3, MAC, 16'h8101, 12'hAAA, 0, 0, 0);
    send("R2 tpid 0081", 16'd80, 3, MAC, 16'h0081, 12'hAAA, 0, 0, 0);

    // R3: every single-bit destination flip
    for (int b = 0; b < 48; b++)
      send("R3 dst flip", 16'd90, 3, MAC ^ (48'd1 << b), 16'h8100, 12'hAAA, 0, 0, 0);

    // R5: every fault combination
    for (int m = 0; m < 16; m++)
      send("R5 priority", m[0] ? 16'd40 : 16'd200, 3, m[2] ? ~MAC : MAC,
           m[1] ? 16'h9100 : 16'h8100, m[3] ? 12'h555 : 12'hAAA, 0, 0, 0);
    check_counters("R5 after priority");

    // R10: idle beat without start marker is ignored
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = {MAC, 16'h0};
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    check("R10 stray beat no result", {63'd0, res_valid}, 64'd0);
    check("R10 stray beat no count", {32'd0, cnt_rx}, {32'd0, mcnt[0]});

    // R10: back-pressure on the result
    res_ready = 1'b0;
    send("R10 stalled result", 16'd300, 3, MAC, 16'h8100, 12'hAAA, 0, 0, 0);
    @(negedge clk);
    check("R10 in_ready low while held", {63'd0, in_ready}, 64'd0);
    check("R10 result held", result_now(), last_exp);
    @(negedge clk);
    check("R10 result still held", result_now(), last_exp);
    res_ready = 1'b1;
    @(negedge clk);
    check("R10 released", {62'd0, res_valid, in_ready}, {62'd0, 1'b0, 1'b1});

    // R4, R6, R9: write and look up every entry
    for (int v = 0; v < 4096; v++) begin
      write_entry(12'(v), 4'(v), 32'(v) * 32'h9E37_79B9);
      send("R4 R6 vid sweep", 16'd128, 3, MAC, 16'h8100, 12'(v), 0, 0, 0);
    end

    // R9: write on the lookup edge sees old content, then new
    send("R9 same-edge old", 16'd128, 3, MAC, 16'h8100, 12'h010, 1, 4'd5, 32'hCAFE_0010);
    send("R9 after write",   16'd128, 3, MAC, 16'h8100, 12'h010, 0, 0, 0);
    write_entry(12'h011, 4'd0, 32'h1234_5678);
    send("R9 invalidated",   16'd128, 3, MAC, 16'h8100, 12'h011, 0, 0, 0);

    @(negedge clk);
    check_counters("R7 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule